// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers forty level-sensitive interrupt sources and presents them to a processor core. Each source has three bits of state: a pending bit that tracks the synchronized input level, an enable bit, and a routing bit. The routing bit sends the source to the fast interrupt line when it is set and to the normal interrupt line when it is clear. The per-source bits are kept in two 32-bit banks. A third output, used while the core is halted, requests a wake-up. A control bit decides whether only enabled sources may wake the core, or any pending source may.

Software reaches the block over a plain 32-bit register bus with byte offsets. Writes take effect at the clock edge. A read returns its word on the edge after the read request. Besides the enable and routing registers, the bus exposes the raw pending bits and a masked view for each output class. It also holds forty priority slots, each naming a source ID with a valid flag. A result word reports, for each class, the highest-priority slot whose source is pending and enabled. A combinational resolver computes this word, and the lowest slot index wins.

Top module: `intc_dual_bank`

## Requirements
- R1: Source n below 32 is bit n of bank 0, and source n of 32 or more is bit n-32 of bank 1. Raw pending is read at 0x10 (bank 0) and 0xAC (bank 1). Bank 1 bits above source 39 read as 0.
- R2: A pending bit equals its source input as sampled SYNC_STAGES (default 2) clock edges earlier. It sets while the input is high and clears when the input goes low.
- R3: Enable is read and written at 0x04 and 0xA0, and routing at 0x08 and 0xA4. Reset clears the pending, enable and routing bits in both banks.
- R4: The normal-class view (0x00, 0x9C) reads pending AND enable AND NOT routing. The fast-class view (0x0C, 0xA8) reads pending AND enable AND routing.
- R5: irq_out is 1 exactly when some source was pending, enabled and routed normal on the previous cycle. fiq_out is the same for sources routed fast.
- R6: The control register at 0x14 holds bit 0. It reads back as last written, with bits 31:1 read as 0, and it resets to 0.
- R7: wake_out is registered. It is 1 when, on the previous cycle, cpu_halted was 1 and some source was pending and either enabled or covered by idle-all. Idle-all is in force when control bit 0 is 0.
- R8: Priority slots 0..31 sit at 0x1C+4k, and slots 32..39 sit at 0xB0+4(k-32). A write stores only bits 31 and 5:0. Slots reset to 0.
- R9: The result word at 0x18 has these fields. Bit 31 is the normal-class hit and bits 21:16 its source ID. Bit 15 is the fast-class hit and bits 5:0 its ID. All other bits are 0. A class with no hit reads ID 0x3F with its hit bit 0. A slot takes part only if its bit 31 is set and its ID is below 40. The lowest matching slot index wins, for each class on its own.
- R10: Reads of unmapped offsets (0xD0..0xFC) return 0. Writes to unmapped offsets, to the two class views, to raw pending and to the result word change no state.
- R11: bus_rdata is loaded from the addressed word on a clock edge where bus_rd is 1. It reflects the state before any write on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Asynchronous source levels |
| cpu_halted | input | 1 | Core is halted |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal-class interrupt request |
| fiq_out | output | 1 | Fast-class interrupt request |
| wake_out | output | 1 | Wake request while halted |

## Verification
The hardest case to reach is the resolver picking between several slots. Two or more valid slots must match the same class at once, and slots that would otherwise match must be skipped because their valid bit is clear or their ID is 40 or more. Directed cases load such slot sets on purpose and then raise the matching sources. Random rounds then draw slot IDs from 0..47 with the valid bit set about three times in four, so collisions and out-of-range IDs recur while source levels, enables and routing change around them. The idle-all wake path is driven directly: the core is halted, a source is raised while it is disabled, and control bit 0 is toggled.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int unsigned ID_W = 6;

  // word indices (byte offset / 4); the bus map depends on them
  localparam logic [5:0] W_IVIEW0  = 6'd0;
  localparam logic [5:0] W_EN0     = 6'd1;
  localparam logic [5:0] W_ROUTE0  = 6'd2;
  localparam logic [5:0] W_FVIEW0  = 6'd3;
  localparam logic [5:0] W_RAW0    = 6'd4;
  localparam logic [5:0] W_CTRL    = 6'd5;
  localparam logic [5:0] W_RESULT  = 6'd6;
  localparam int unsigned W_SLOT_LO = 7;
  localparam logic [5:0] W_IVIEW1  = 6'd39;
  localparam logic [5:0] W_EN1     = 6'd40;
  localparam logic [5:0] W_ROUTE1  = 6'd41;
  localparam logic [5:0] W_FVIEW1  = 6'd42;
  localparam logic [5:0] W_RAW1    = 6'd43;
  localparam int unsigned W_SLOT_HI = 44;

  typedef struct packed {
    logic            valid;
    logic [ID_W-1:0] id;
  } slot_t;

  typedef struct packed {
    logic            irq_hit;
    logic [ID_W-1:0] irq_id;
    logic            fiq_hit;
    logic [ID_W-1:0] fiq_id;
  } result_t;

  function automatic logic [31:0] pack_result(result_t r);
    return {r.irq_hit, 9'd0, r.irq_id, r.fiq_hit, 9'd0, r.fiq_id};
  endfunction

  function automatic logic [31:0] pack_slot(slot_t s);
    return {s.valid, 25'd0, s.id};
  endfunction
endpackage

// File: rtl/intc_src_sync.sv
`timescale 1ns/1ps
module intc_src_sync #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] level_in,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= level_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign pend = stage_q[STAGES-1];
endmodule

// File: rtl/intc_prio_table.sv
`timescale 1ns/1ps
module intc_prio_table
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 40,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [31:0]                 wr_data,
  output slot_t [NUM_SLOTS-1:0]       slots
);
  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          slots[g] <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          slots[g].valid <= wr_data[31];
          slots[g].id    <= wr_data[ID_W-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/intc_resolver.sv
`timescale 1ns/1ps
module intc_resolver
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 40,
  parameter int unsigned NUM_SLOTS = 40
) (
  input  slot_t [NUM_SLOTS-1:0] slots,
  input  logic  [NUM_SRC-1:0]   masked,
  input  logic  [NUM_SRC-1:0]   route,
  output result_t               res
);
  logic [NUM_SLOTS-1:0] hit_fast, hit_norm;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
      logic ok;
      logic [63:0] m_pad, r_pad;
      assign m_pad = 64'(masked);
      assign r_pad = 64'(route);
      assign ok = slots[g].valid && (32'(slots[g].id) < NUM_SRC);
      assign hit_fast[g] = ok && m_pad[slots[g].id] &&  r_pad[slots[g].id];
      assign hit_norm[g] = ok && m_pad[slots[g].id] && !r_pad[slots[g].id];
    end
  endgenerate

  // walk from the last slot down so the lowest index overrides
  always_comb begin
    res.irq_hit = 1'b0;
    res.irq_id  = '1;
    res.fiq_hit = 1'b0;
    res.fiq_id  = '1;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_fast[i]) begin
        res.fiq_hit = 1'b1;
        res.fiq_id  = slots[i].id;
      end
      if (hit_norm[i]) begin
        res.irq_hit = 1'b1;
        res.irq_id  = slots[i].id;
      end
    end
  end
endmodule

// File: rtl/intc_dual_bank.sv
`timescale 1ns/1ps
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 40,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  localparam int unsigned WI_W       = ADDR_W - 2,
  localparam int unsigned SLOT_IDX_W = $clog2(NUM_SRC),
  localparam int unsigned HI_SLOTS   = NUM_SRC - 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               cpu_halted,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out,
  output logic               fiq_out,
  output logic               wake_out
);
  logic [NUM_SRC-1:0] pend, en_q, route_q, masked;
  logic               ctrl_q;
  slot_t [NUM_SRC-1:0] slots;
  result_t            res;

  logic [WI_W-1:0]    wi;
  logic [31:0]        wi32, slot_off;
  logic               slot_hit, unmapped;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [31:0]        rd_word;

  intc_src_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .level_in(src_level), .pend(pend)
  );

  assign wi   = bus_addr[ADDR_W-1:2];
  assign wi32 = 32'(wi);

  // slot decode: two separate windows in the word map
  always_comb begin
    slot_hit = 1'b0;
    slot_off = '0;
    if (wi32 >= W_SLOT_LO && wi32 < W_SLOT_LO + 32) begin
      slot_hit = 1'b1;
      slot_off = wi32 - W_SLOT_LO;
    end else if (wi32 >= W_SLOT_HI && wi32 < W_SLOT_HI + HI_SLOTS) begin
      slot_hit = 1'b1;
      slot_off = wi32 - W_SLOT_HI + 32;
    end
  end
  assign slot_idx = slot_off[SLOT_IDX_W-1:0];

  intc_prio_table #(.NUM_SLOTS(NUM_SRC)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && slot_hit), .wr_idx(slot_idx), .wr_data(bus_wdata),
    .slots(slots)
  );

  assign masked = pend & en_q;

  intc_resolver #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SRC)) u_resolver (
    .slots(slots), .masked(masked), .route(route_q), .res(res)
  );

  function automatic logic [NUM_SRC-1:0] merge_bank(logic [NUM_SRC-1:0] cur,
                                                    logic bank, logic [31:0] d);
    logic [63:0] p;
    p = 64'(cur);
    if (bank) p[63:32] = d;
    else      p[31:0]  = d;
    return p[NUM_SRC-1:0];
  endfunction

  function automatic logic [31:0] bank_word(logic [NUM_SRC-1:0] v, logic bank);
    logic [63:0] p;
    p = 64'(v);
    return bank ? p[63:32] : p[31:0];
  endfunction

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '0;
      ctrl_q  <= 1'b0;
    end else if (bus_wr) begin
      unique case (6'(wi))
        W_EN0:    en_q    <= merge_bank(en_q, 1'b0, bus_wdata);
        W_EN1:    en_q    <= merge_bank(en_q, 1'b1, bus_wdata);
        W_ROUTE0: route_q <= merge_bank(route_q, 1'b0, bus_wdata);
        W_ROUTE1: route_q <= merge_bank(route_q, 1'b1, bus_wdata);
        W_CTRL:   ctrl_q  <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_word  = '0;
    unmapped = 1'b0;
    case (6'(wi))
      W_IVIEW0: rd_word = bank_word(masked & ~route_q, 1'b0);
      W_IVIEW1: rd_word = bank_word(masked & ~route_q, 1'b1);
      W_FVIEW0: rd_word = bank_word(masked & route_q, 1'b0);
      W_FVIEW1: rd_word = bank_word(masked & route_q, 1'b1);
      W_EN0:    rd_word = bank_word(en_q, 1'b0);
      W_EN1:    rd_word = bank_word(en_q, 1'b1);
      W_ROUTE0: rd_word = bank_word(route_q, 1'b0);
      W_ROUTE1: rd_word = bank_word(route_q, 1'b1);
      W_RAW0:   rd_word = bank_word(pend, 1'b0);
      W_RAW1:   rd_word = bank_word(pend, 1'b1);
      W_CTRL:   rd_word = {31'd0, ctrl_q};
      W_RESULT: rd_word = pack_result(res);
      default: begin
        if (slot_hit) rd_word = pack_slot(slots[slot_idx]);
        else          unmapped = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      fiq_out   <= 1'b0;
      wake_out  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq_out  <= |(masked & ~route_q);
      fiq_out  <= |(masked & route_q);
      wake_out <= cpu_halted && |(pend & (en_q | {NUM_SRC{~ctrl_q}}));
    end
  end

  // assertions
  assert_irq_line_R5: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|(pend & en_q & ~route_q)));
  assert_fiq_line_R5: assert property (@(posedge clk) disable iff (rst)
    fiq_out == $past(|(pend & en_q & route_q)));
  assert_wake_needs_halt_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_halted) |-> !wake_out);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && unmapped) |-> (bus_rdata == 32'd0));
  assert_norm_hit_real_R9: assert property (@(posedge clk) disable iff (rst)
    res.irq_hit |-> (32'(res.irq_id) < NUM_SRC) && masked[res.irq_id[SLOT_IDX_W-1:0]]
                    && !route_q[res.irq_id[SLOT_IDX_W-1:0]]);
  assert_fast_hit_real_R9: assert property (@(posedge clk) disable iff (rst)
    res.fiq_hit |-> (32'(res.fiq_id) < NUM_SRC) && masked[res.fiq_id[SLOT_IDX_W-1:0]]
                    && route_q[res.fiq_id[SLOT_IDX_W-1:0]]);
endmodule

// File: tb/intc_dual_bank_bench.sv
`timescale 1ns/1ps
module intc_dual_bank_bench;
  localparam int NS = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] src_level = '0;
  logic cpu_halted = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out, fiq_out, wake_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_src, m_en, m_rt;
  logic        m_ctrl;
  logic [31:0] m_slot [NS];

  always #2.5 clk = ~clk;

  intc_dual_bank u_intc_dual_bank (
    .clk(clk), .rst(rst), .src_level(src_level), .cpu_halted(cpu_halted),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic int slot_of(logic [7:0] a);
    if (a >= 8'h1C && a <= 8'h98) return (a - 8'h1C) / 4;
    if (a >= 8'hB0 && a <= 8'hCC) return 32 + (a - 8'hB0) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] exp_result();
    logic [31:0] r;
    logic fdone, ndone;
    logic [63:0] mk;
    r = 32'h003F003F; fdone = 0; ndone = 0;
    mk = m_src & m_en;
    for (int k = 0; k < NS; k++) begin
      int id;
      id = int'(m_slot[k][5:0]);
      if (m_slot[k][31] && id < NS && mk[id]) begin
        if (m_rt[id] && !fdone) begin r[15:0] = 16'h8000 | 16'(id); fdone = 1; end
        if (!m_rt[id] && !ndone) begin r[31:16] = 16'h8000 | 16'(id); ndone = 1; end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    logic [63:0] mk;
    mk = m_src & m_en;
    case (a)
      8'h00: return 32'(mk & ~m_rt);
      8'h9C: return 32'((mk & ~m_rt) >> 32);
      8'h0C: return 32'(mk & m_rt);
      8'hA8: return 32'((mk & m_rt) >> 32);
      8'h04: return 32'(m_en);
      8'hA0: return 32'(m_en >> 32);
      8'h08: return 32'(m_rt);
      8'hA4: return 32'(m_rt >> 32);
      8'h10: return 32'(m_src);
      8'hAC: return 32'(m_src >> 32);
      8'h14: return {31'd0, m_ctrl};
      8'h18: return exp_result();
      default: begin
        if (slot_of(a) >= 0) return m_slot[slot_of(a)];
        return 32'd0;
      end
    endcase
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h04: m_en[31:0] = d;
      8'hA0: m_en[63:32] = d & 32'h000000FF;
      8'h08: m_rt[31:0] = d;
      8'hA4: m_rt[63:32] = d & 32'h000000FF;
      8'h14: m_ctrl = d[0];
      default: if (slot_of(a) >= 0) m_slot[slot_of(a)] = d & 32'h8000003F;
    endcase
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic read_check(string req, logic [7:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp_read(a));
  endtask

  task automatic set_src(logic [63:0] v);
    @(negedge clk);
    src_level = v[NS-1:0];
    m_src = v & 64'h000000FF_FFFFFFFF;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_lines(string tag);
    logic [63:0] mk;
    logic exp_wake;
    mk = m_src & m_en;
    exp_wake = cpu_halted && ((m_src & (m_en | (m_ctrl ? 64'd0 : ~64'd0))) != 0);
    check({"R5 irq ", tag}, {31'd0, irq_out}, {31'd0, (mk & ~m_rt) != 0});
    check({"R5 fiq ", tag}, {31'd0, fiq_out}, {31'd0, (mk & m_rt) != 0});
    check({"R7 wake ", tag}, {31'd0, wake_out}, {31'd0, exp_wake});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1D5E_77A1));
    m_src = 0; m_en = 0; m_rt = 0; m_ctrl = 0;
    for (int k = 0; k < NS; k++) m_slot[k] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    settle();

    // reset state (R3, R6, R8, R9)
    check_lines("reset");
    read_check("R3 enable0 reset", 8'h04);
    read_check("R3 route1 reset", 8'hA4);
    read_check("R6 ctrl reset", 8'h14);
    read_check("R8 slot0 reset", 8'h1C);
    read_check("R9 empty result", 8'h18);

    // R1/R2: source 39 lands in bank 1 bit 7
    set_src(64'h80_0000_0000); settle();
    read_check("R1 raw bank1", 8'hAC);
    read_check("R1 raw bank0", 8'h10);
    set_src(64'h0); settle();
    read_check("R2 clears on low", 8'hAC);

    // R3: bank 1 upper bits read zero
    bus_write(8'hA0, 32'hFFFF_FFFF);
    read_check("R3 enable1 width", 8'hA0);
    bus_write(8'hA0, 32'h0);

    // R4/R5: source 3 routed fast
    bus_write(8'h04, 32'h0000_0088);
    bus_write(8'h08, 32'h0000_0008);
    set_src(64'h88); settle();
    check_lines("fast src3");
    read_check("R4 fast view0", 8'h0C);
    read_check("R4 norm view0", 8'h00);

    // R9: lowest slot wins, invalid/out-of-range slots skipped
    bus_write(8'h1C, 32'h8000_002D);          // slot0: id 45, skipped
    bus_write(8'h20, 32'h0000_0003);          // slot1: not valid
    bus_write(8'h24, 32'h8000_0007);          // slot2: id 7 normal
    bus_write(8'h30, 32'h8000_0003);          // slot5: id 3 fast
    bus_write(8'h34, 32'h8000_0007);          // slot6: id 7 again
    bus_write(8'hCC, 32'h8000_0003);          // slot39: id 3 again
    settle();
    read_check("R9 pick lowest", 8'h18);
    bus_write(8'h20, 32'h8000_0003);          // slot1 now valid
    read_check("R9 slot1 overrides", 8'h18);

    // R8: write mask on last slot
    bus_write(8'hCC, 32'hFFFF_FFFF);
    read_check("R8 slot39 mask", 8'hCC);
    read_check("R8 slot32 addr", 8'hB0);

    // R10: unmapped and read-only writes
    bus_write(8'hD0, 32'hFFFF_FFFF);
    read_check("R10 unmapped read", 8'hD0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'h0);
    bus_write(8'hAC, 32'hFFFF_FFFF);
    read_check("R10 raw unchanged", 8'h10);
    read_check("R10 result unchanged", 8'h18);
    read_check("R10 enable unchanged", 8'h04);

    // R11: read on the same edge as a write sees old value
    @(negedge clk);
    bus_wr = 1; bus_rd = 1; bus_addr = 8'h08; bus_wdata = 32'h0000_00F0;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check("R11 read before write", bus_rdata, 32'h0000_0008);
    model_write(8'h08, 32'h0000_00F0);

    // R7/R6: idle-all wake with a disabled source
    bus_write(8'h04, 32'h0);
    bus_write(8'hA0, 32'h0);
    set_src(64'h10_0000_0000);
    cpu_halted = 1;
    bus_write(8'h14, 32'h1);
    settle();
    check_lines("idle limited");
    read_check("R6 ctrl readback", 8'h14);
    bus_write(8'h14, 32'hFFFF_FFFE);
    settle();
    check_lines("idle all");
    cpu_halted = 0; settle();
    check_lines("not halted");

    // random rounds
    for (int it = 0; it < 200; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      if (op == 0) set_src({$urandom(), $urandom()});
      if (op == 1) bus_write({$urandom_range(0, 63), 2'b00}, $urandom());
      if (op == 2) bus_write($urandom_range(0, 1) ? 8'h04 : 8'hA0, $urandom());
      if (op == 3) bus_write($urandom_range(0, 1) ? 8'h08 : 8'hA4, $urandom());
      if (op == 4) begin
        int k;
        logic [31:0] v;
        k = int'($urandom_range(0, NS - 1));
        v = {($urandom_range(0, 3) != 0), 25'd0, 6'($urandom_range(0, 47))};
        bus_write(k < 32 ? 8'(8'h1C + 4 * k) : 8'(8'hB0 + 4 * (k - 32)), v);
      end
      if (op == 5) begin
        cpu_halted = 1'($urandom_range(0, 1));
        bus_write(8'h14, $urandom());
      end
      settle();
      check_lines("random");
      read_check("R9 random result", 8'h18);
      read_check("R4 R1 random word", {$urandom_range(0, 63), 2'b00});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule